// File: doc/BRIEF.md
# MMU fault status and control unit

This block is the register-side shell around a device memory management unit. It holds the unit's enable controls and the base address of the translation table. It also collects fault pulses from the translation path into a sticky status register. The status is gated by an enable mask to form a single level interrupt, and the block keeps the device address of the first fault so that software can inspect it.

Software reaches it through a plain 32-bit register port. Writes take effect on the clock edge, and reads are combinational on the address. The lookup logic and the table walker stay outside and only deliver one-cycle event pulses with the address they concern. Software picks the interrupt mask to match the walker mode. With the walker on, it unmasks the fault sources plus the table-walk fault (mask 0x1E). With the walker off, it unmasks the fault sources plus the TLB miss (mask 0x17).

Register offsets (byte addresses): 0x00 identification, 0x04 event status, 0x08 interrupt mask, 0x0C control, 0x10 fault address, 0x14 table base.

Top module: `mmu_fault_ctrl`

## Requirements
- R1: The identification register at 0x00 reads 0x00000011: major number 1 in bits 7:4 and minor number 1 in bits 3:0. Writes to it have no effect.
- R2: The control register at 0x0C stores all 32 written bits and reads them back. Bit 1 drives `mmu_on`, bit 2 drives `walk_on` and bit 3 drives `emu_tlb`, each one cycle after the write. Clearing bits 3:1 leaves the other bits as they were.
- R3: Event bits are: 0 TLB miss, 1 translation fault, 2 emulator miss, 3 table-walk fault, 4 multi-hit fault. A pulse on `evt[i]` sets status bit i at the next edge, whatever the mask. Status bits 31:5 read zero.
- R4: Writing the status register clears exactly the status bits written as one, and leaves the others unchanged.
- R5: A status bit whose event arrives in the same cycle as a write that clears it stays set.
- R6: `irq` is high exactly when some status bit is set together with its mask bit. It stays high until software clears those bits or masks them.
- R7: The fault-address register at 0x10 captures `evt_addr` on an event cycle only if no status bit was set before that cycle. A later event keeps the first address while any status bit remains set.
- R8: The table-base register at 0x14 stores bits 31:14 of the written value, and bits 13:0 always read zero, so the base is 16 KB aligned. It drives `ttb_base`.
- R9: The interrupt mask at 0x08 stores bits 4:0, and bits 31:5 read zero. With mask 0x1E a TLB miss raises no interrupt but a table-walk fault does. With mask 0x17 the reverse holds.
- R10: Reads of any offset not listed read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt | input | 5 | One-cycle fault event pulses from the translation path |
| evt_addr | input | 32 | Device address that goes with `evt` |
| irq | output | 1 | Level interrupt |
| mmu_on | output | 1 | Translation enable |
| walk_on | output | 1 | Table walker enable |
| emu_tlb | output | 1 | Emulator TLB mode |
| ttb_base | output | 32 | Aligned translation table base |

## Verification
The assertions check on every cycle the properties of single transitions. An event sets its status bit. A cleared bit drops unless it is re-raised in the same cycle. An enabled event raises the interrupt. The fault address is frozen while status is pending. A table-base write lands aligned. The bench sweeps every pairing of status pattern against clear pattern, and of status pattern against mask, to show the whole W1C and gating arithmetic. It also runs the scenarios that span several cycles: first-fault retention across successive events, the two walker mask choices, control bits preserved when the unit is disabled, the read-only identification register and zero reads from unmapped offsets.

// File: rtl/mmu_fault_ctrl.sv
module mmu_fault_ctrl #(
  parameter int          AW        = 8,
  parameter int          NSRC      = 5,
  parameter int          ALIGN_LSB = 14,
  parameter logic [31:0] IDENT     = 32'h0000_0011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NSRC-1:0] evt,
  input  logic [31:0]   evt_addr,
  output logic          irq,
  output logic          mmu_on,
  output logic          walk_on,
  output logic          emu_tlb,
  output logic [31:0]   ttb_base
);
  localparam logic [AW-1:0] A_ID   = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_MASK = AW'(8'h08);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h0C);
  localparam logic [AW-1:0] A_FADR = AW'(8'h10);
  localparam logic [AW-1:0] A_TTB  = AW'(8'h14);
  localparam int HI = 32 - ALIGN_LSB;

  logic [NSRC-1:0] stat_q, mask_q, clr;
  logic [31:0]     ctrl_q, fadr_q;
  logic [HI-1:0]   ttb_q;

  assign clr = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      fadr_q <= '0;
      ttb_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      if (|evt && stat_q == '0) fadr_q <= evt_addr;
      if (bus_wr) begin
        if (bus_addr == A_MASK) mask_q <= bus_wdata[NSRC-1:0];
        if (bus_addr == A_CTRL) ctrl_q <= bus_wdata;
        if (bus_addr == A_TTB)  ttb_q  <= bus_wdata[31:ALIGN_LSB];
      end
    end
  end

  assign irq      = |(stat_q & mask_q);
  assign mmu_on   = ctrl_q[1];
  assign walk_on  = ctrl_q[2];
  assign emu_tlb  = ctrl_q[3];
  assign ttb_base = {ttb_q, {ALIGN_LSB{1'b0}}};

  always_comb begin
    unique case (bus_addr)
      A_ID:    bus_rdata = IDENT;
      A_STAT:  bus_rdata = 32'(stat_q);
      A_MASK:  bus_rdata = 32'(mask_q);
      A_CTRL:  bus_rdata = ctrl_q;
      A_FADR:  bus_rdata = fadr_q;
      A_TTB:   bus_rdata = ttb_base;
      default: bus_rdata = '0;
    endcase
  end

  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((stat_q & $past(clr) & ~$past(evt)) == '0));

  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & evt) != '0) |=> ((stat_q & $past(clr & evt)) != '0));

  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & mask_q) != '0 && !(bus_wr && bus_addr == A_MASK)) |=> irq);

  p_first_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |=> $stable(fadr_q));

  p_ttb_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TTB) |=>
      (ttb_base[ALIGN_LSB-1:0] == '0 && ttb_base[31:ALIGN_LSB] == $past(bus_wdata[31:ALIGN_LSB])));

  p_ctrl_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |=>
      ({emu_tlb, walk_on, mmu_on} == $past(bus_wdata[3:1])));
endmodule

// File: tb/test_mmu_fault_ctrl.sv
module test_mmu_fault_ctrl;
  logic clk = 0, rst_n = 0, bus_wr = 0, irq, mmu_on, walk_on, emu_tlb;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, evt_addr = 0, ttb_base;
  logic [4:0] evt = 0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mmu_fault_ctrl i_mmu_fault_ctrl (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .evt, .evt_addr, .irq, .mmu_on, .walk_on, .emu_tlb, .ttb_base);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [7:0] a, logic [31:0] d, logic [4:0] e, logic [31:0] ea);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; evt = e; evt_addr = ea;
    @(negedge clk);
    bus_wr = 0; evt = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rst_n = 1;
    rd(8'h04, v); chk("R3 reset status", v, 0);
    chk("R6 reset irq", 32'(irq), 0);
    chk("R2 reset ctrl", 32'({emu_tlb, walk_on, mmu_on}), 0);

    rd(8'h00, v); chk("R1 ident", v, 32'h11);
    chk("R1 major", 32'(v[7:4]), 1);
    chk("R1 minor", 32'(v[3:0]), 1);
    cyc(1, 8'h00, 32'hFFFF_FFFF, 0, 0);
    rd(8'h00, v); chk("R1 write ignored", v, 32'h11);

    for (int a = 8'h18; a < 8'h40; a += 4) begin
      rd(8'(a), v); chk("R10 unmapped", v, 0);
    end

    for (int s = 0; s < 32; s++)
      for (int c = 0; c < 32; c++) begin
        cyc(1, 8'h04, 32'h1F, 0, 0);
        cyc(0, 8'h00, 0, 5'(s), 32'h1000);
        rd(8'h04, v); chk("R3 status set", v, 32'(s));
        cyc(1, 8'h04, 32'hFFFF_FFE0 | 32'(c), 0, 0);
        rd(8'h04, v); chk("R4 w1c", v, 32'(s & ~c));
      end

    for (int m = 0; m < 32; m++) begin
      cyc(1, 8'h08, 32'hFFFF_FFE0 | 32'(m), 0, 0);
      rd(8'h08, v); chk("R9 mask read", v, 32'(m));
      for (int s = 0; s < 32; s++) begin
        cyc(1, 8'h04, 32'h1F, 0, 0);
        cyc(0, 8'h00, 0, 5'(s), 0);
        chk("R6 irq gate", 32'(irq), 32'((s & m) != 0));
        cyc(0, 8'h00, 0, 0, 0);
        chk("R6 irq held", 32'(irq), 32'((s & m) != 0));
      end
    end

    cyc(1, 8'h04, 32'h1F, 0, 0);
    cyc(0, 8'h00, 0, 5'b00001, 0);
    cyc(1, 8'h04, 32'h1, 5'b00001, 0);
    rd(8'h04, v); chk("R5 set wins over clear", v, 1);
    cyc(1, 8'h04, 32'h1, 5'b00100, 0);
    rd(8'h04, v); chk("R5 other bit cleared", v, 32'h4);

    cyc(1, 8'h04, 32'h1F, 0, 0);
    cyc(0, 8'h00, 0, 5'b00010, 32'hAAAA_1000);
    cyc(0, 8'h00, 0, 5'b10000, 32'hBBBB_2000);
    rd(8'h10, v); chk("R7 first fault kept", v, 32'hAAAA_1000);
    cyc(1, 8'h04, 32'h1F, 0, 0);
    cyc(0, 8'h00, 0, 5'b01000, 32'hCCCC_3000);
    rd(8'h10, v); chk("R7 new capture after clear", v, 32'hCCCC_3000);

    cyc(1, 8'h08, 32'h1E, 0, 0);
    cyc(1, 8'h04, 32'h1F, 0, 0);
    cyc(0, 8'h00, 0, 5'b00001, 0);
    chk("R9 walk-on TLB miss masked", 32'(irq), 0);
    cyc(0, 8'h00, 0, 5'b01000, 0);
    chk("R9 walk-on walk fault", 32'(irq), 1);
    cyc(1, 8'h08, 32'h17, 0, 0);
    chk("R9 walk-off walk fault masked, miss on", 32'(irq), 1);
    cyc(1, 8'h04, 32'h1, 0, 0);
    chk("R9 walk-off walk fault masked", 32'(irq), 0);

    cyc(1, 8'h0C, 32'h5A5A_A5A6, 0, 0);
    rd(8'h0C, v); chk("R2 ctrl read", v, 32'h5A5A_A5A6);
    chk("R2 ctrl outputs", 32'({emu_tlb, walk_on, mmu_on}), 32'h3);
    cyc(1, 8'h0C, 32'h5A5A_A5A6 & ~32'hE, 0, 0);
    rd(8'h0C, v); chk("R2 disable keeps others", v, 32'h5A5A_A5A0);
    chk("R2 disabled outputs", 32'({emu_tlb, walk_on, mmu_on}), 0);
    cyc(1, 8'h0C, 32'h8, 0, 0);
    chk("R2 emu bit", 32'({emu_tlb, walk_on, mmu_on}), 32'h4);

    for (int k = 0; k < 32; k++) begin
      logic [31:0] d;
      d = 32'h9E37_79B9 * (k + 1);
      cyc(1, 8'h14, d, 0, 0);
      rd(8'h14, v); chk("R8 ttb read", v, d & 32'hFFFF_C000);
      chk("R8 ttb port", ttb_base, d & 32'hFFFF_C000);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule